// File: doc/BRIEF.md
# DMA Modulo Address Generator

This block produces the running source and destination addresses for a single DMA channel. A load strobe gives it a start address, a signed per-transfer step, a window size and a transfer-size code for each side. It also takes one shared signed minor-loop adjustment and a separate enable for each side. After the load, each source-read-done strobe moves the source address by its step, and each destination-write-done strobe moves the destination address by its step. A minor-loop-done strobe adds the adjustment to every side whose enable is set.

Each side can be held inside a power-of-two circular window. A nonzero window value N lets only the N least significant address bits follow the sum, and the bits above them keep the values they had when the address was loaded. This gives a circular queue without any compare logic. Transfer-size codes are checked at load time. A reserved code raises a configuration error, and the error stops both addresses from moving until the next load.

Top module: `dma_modaddr_gen`

## Requirements
- R1: Reset clears both addresses and `cfg_err` to zero. A `load` pulse writes `ld_src_addr` and `ld_dst_addr` into `src_addr` and `dst_addr`, and the new values are visible one clock after the load edge.
- R2: With window value 0, a `src_step` pulse sets `src_addr` to the full 32-bit sum of `src_addr` and the sign-extended 16-bit source step, wrapping modulo 2^32.
- R3: With window value 0, a `dst_step` pulse sets `dst_addr` to the full 32-bit sum of `dst_addr` and the sign-extended 16-bit destination step. The source and destination fields are independent.
- R4: A step whose bit 15 is set counts as negative. For example, 0xFFFC moves the address down by 4.
- R5: With a nonzero window value N (0..31), only address bits [N-1:0] take the low bits of address plus step. Bits [31:N] keep their loaded values. A 16-byte queue (N=4, step +4) returns to its base after four steps.
- R6: On `minor_done`, each side whose loaded minor-loop enable is 1 adds the sign-extended 20-bit minor-loop offset, under that side's window mask. A side whose enable is 0 is not changed by `minor_done`.
- R7: Size codes 0, 1, 2, 3 and 5 are legal. Codes 4, 6 and 7 are reserved. One clock after a load, `cfg_err` is 1 exactly when the source code or the destination code just loaded is reserved.
- R8: While `cfg_err` is 1, step and minor-loop strobes leave both addresses unchanged. `cfg_err` changes only on a load.
- R9: If a step and `minor_done` arrive in the same cycle, each is applied exactly once: the step first, then the minor-loop offset, both under the window. With no strobe, an address holds its value.
- R10: A `load` in the same cycle as any strobe takes priority, so the loaded values appear unchanged by the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Writes all `ld_*` fields |
| ld_src_addr | input | 32 | Source start address |
| ld_src_off | input | 16 | Signed source step |
| ld_src_mod | input | 5 | Source window bits, 0 = off |
| ld_src_size | input | 3 | Source size code |
| ld_src_mlo_en | input | 1 | Apply minor-loop offset to source |
| ld_dst_addr | input | 32 | Destination start address |
| ld_dst_off | input | 16 | Signed destination step |
| ld_dst_mod | input | 5 | Destination window bits, 0 = off |
| ld_dst_size | input | 3 | Destination size code |
| ld_dst_mlo_en | input | 1 | Apply minor-loop offset to destination |
| ld_mlo_off | input | 20 | Signed minor-loop offset |
| src_step | input | 1 | Source read completed |
| dst_step | input | 1 | Destination write completed |
| minor_done | input | 1 | Minor loop completed |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| cfg_err | output | 1 | Reserved size code loaded |

## Verification
Every result in this block, including the addresses after a load or a strobe and the `cfg_err` flag after a load, is registered once, so each is due on the first rising edge after the stimulus. The bench changes inputs on the falling edge and drops each strobe on the next falling edge. It reads the outputs at that same falling edge, half a cycle after the edge that updated them. In the sweeps, the expected address after k steps is computed as the loaded upper bits joined with the low bits of the start address plus k times the step. This checks every strobe against a closed form rather than against the previous output.

// File: rtl/dma_mag_pkg.sv
package dma_mag_pkg;

   localparam int SIZE_W = 3;

   // Legal transfer-size encodings; unlisted codes are reserved
   typedef enum logic [SIZE_W-1:0] {
      XSZ_BYTE   = 3'd0,
      XSZ_HALF   = 3'd1,
      XSZ_WORD   = 3'd2,
      XSZ_DWORD  = 3'd3,
      XSZ_LINE32 = 3'd5
   } xfer_size_e;

   // Ways to form the combined step + minor-loop next address
   localparam int SUM_CHAINED = 0;
   localparam int SUM_MERGED  = 1;

endpackage

// File: rtl/dma_mag_size_chk.sv
module dma_mag_size_chk
   import dma_mag_pkg::*;
(
   input  logic [SIZE_W-1:0] code,
   output logic              illegal
);

   always_comb begin
      case (code)
         XSZ_BYTE, XSZ_HALF, XSZ_WORD, XSZ_DWORD, XSZ_LINE32: illegal = 1'b0;
         default:                                             illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/dma_mag_side.sv
module dma_mag_side
   import dma_mag_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 16,
   parameter int MLO_W     = 20,
   parameter int MOD_W     = 5,
   parameter int SUM_STYLE = SUM_CHAINED
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [OFF_W-1:0]  ld_off,
   input  logic [MOD_W-1:0]  ld_mod,
   input  logic [SIZE_W-1:0] ld_size,
   input  logic              ld_mlo_en,
   input  logic [MLO_W-1:0]  ld_mlo_off,
   input  logic              step,
   input  logic              minor_done,
   input  logic              hold,
   output logic [ADDR_W-1:0] addr,
   output logic              size_illegal
);

   localparam int OFF_EXT = ADDR_W - OFF_W;
   localparam int MLO_EXT = ADDR_W - MLO_W;

   if (OFF_W >= ADDR_W) begin : g_bad_off
      $error("dma_mag_side: OFF_W must be below ADDR_W");
   end
   if (MLO_W >= ADDR_W) begin : g_bad_mlo
      $error("dma_mag_side: MLO_W must be below ADDR_W");
   end
   if ((2 ** MOD_W) > 2 * ADDR_W) begin : g_bad_mod
      $error("dma_mag_side: MOD_W is wider than the address needs");
   end
   if (SUM_STYLE != SUM_CHAINED && SUM_STYLE != SUM_MERGED) begin : g_bad_style
      $error("dma_mag_side: unknown SUM_STYLE");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [OFF_W-1:0]  off_q;
   logic [MOD_W-1:0]  mod_q;
   logic [MLO_W-1:0]  mlo_q;
   logic              mlo_en_q;

   logic [ADDR_W-1:0] win_mask;
   logic [ADDR_W-1:0] step_term;
   logic [ADDR_W-1:0] mlo_term;
   logic [ADDR_W-1:0] next_addr;
   logic              apply_mlo;
   logic              advance;

   dma_mag_size_chk u_size (
      .code    (ld_size),
      .illegal (size_illegal)
   );

   // Window mask: bit b may change when the window is off or b < mod_q
   for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
      assign win_mask[b] = (mod_q == '0) || (32'(mod_q) > 32'(b));
   end

   assign apply_mlo = minor_done && mlo_en_q;
   assign step_term = step ? {{OFF_EXT{off_q[OFF_W-1]}}, off_q} : '0;
   assign mlo_term  = apply_mlo ? {{MLO_EXT{mlo_q[MLO_W-1]}}, mlo_q} : '0;
   assign advance   = !hold && (step || apply_mlo);

   if (SUM_STYLE == SUM_CHAINED) begin : g_chained
      logic [ADDR_W-1:0] sum1, mid, sum2;
      always_comb begin
         sum1      = addr_q + step_term;
         mid       = (addr_q & ~win_mask) | (sum1 & win_mask);
         sum2      = mid + mlo_term;
         next_addr = (mid & ~win_mask) | (sum2 & win_mask);
      end
   end else begin : g_merged
      logic [ADDR_W-1:0] sum3;
      always_comb begin
         sum3      = addr_q + step_term + mlo_term;
         next_addr = (addr_q & ~win_mask) | (sum3 & win_mask);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         off_q    <= '0;
         mod_q    <= '0;
         mlo_q    <= '0;
         mlo_en_q <= 1'b0;
      end else if (load) begin
         addr_q   <= ld_addr;
         off_q    <= ld_off;
         mod_q    <= ld_mod;
         mlo_q    <= ld_mlo_off;
         mlo_en_q <= ld_mlo_en;
      end else if (advance) begin
         addr_q   <= next_addr;
      end
   end

   assign addr = addr_q;

   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(ld_addr));                                    // R1
   AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ((addr_q ^ $past(addr_q)) & ~$past(win_mask)) == '0);        // R5
   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !load) |=> $stable(addr_q));                                  // R8
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step && !minor_done) |=> $stable(addr_q));                  // R9
   AST_MLO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step && !mlo_en_q) |=> $stable(addr_q));                    // R6

endmodule

// File: rtl/dma_modaddr_gen.sv
module dma_modaddr_gen
   import dma_mag_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 16,
   parameter int MLO_W     = 20,
   parameter int MOD_W     = 5,
   parameter int SUM_STYLE = SUM_CHAINED
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_src_addr,
   input  logic [OFF_W-1:0]  ld_src_off,
   input  logic [MOD_W-1:0]  ld_src_mod,
   input  logic [2:0]        ld_src_size,
   input  logic              ld_src_mlo_en,
   input  logic [ADDR_W-1:0] ld_dst_addr,
   input  logic [OFF_W-1:0]  ld_dst_off,
   input  logic [MOD_W-1:0]  ld_dst_mod,
   input  logic [2:0]        ld_dst_size,
   input  logic              ld_dst_mlo_en,
   input  logic [MLO_W-1:0]  ld_mlo_off,
   input  logic              src_step,
   input  logic              dst_step,
   input  logic              minor_done,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              cfg_err
);

   if (SIZE_W != 3) begin : g_bad_size
      $error("dma_modaddr_gen: size code must be 3 bits");
   end

   logic src_ill, dst_ill;
   logic err_q;

   dma_mag_side #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MLO_W(MLO_W), .MOD_W(MOD_W), .SUM_STYLE(SUM_STYLE)
   ) u_src (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .ld_addr      (ld_src_addr),
      .ld_off       (ld_src_off),
      .ld_mod       (ld_src_mod),
      .ld_size      (ld_src_size),
      .ld_mlo_en    (ld_src_mlo_en),
      .ld_mlo_off   (ld_mlo_off),
      .step         (src_step),
      .minor_done   (minor_done),
      .hold         (err_q),
      .addr         (src_addr),
      .size_illegal (src_ill)
   );

   dma_mag_side #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MLO_W(MLO_W), .MOD_W(MOD_W), .SUM_STYLE(SUM_STYLE)
   ) u_dst (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .ld_addr      (ld_dst_addr),
      .ld_off       (ld_dst_off),
      .ld_mod       (ld_dst_mod),
      .ld_size      (ld_dst_size),
      .ld_mlo_en    (ld_dst_mlo_en),
      .ld_mlo_off   (ld_mlo_off),
      .step         (dst_step),
      .minor_done   (minor_done),
      .hold         (err_q),
      .addr         (dst_addr),
      .size_illegal (dst_ill)
   );

   // Error is formed only from the codes presented with a load
   always_ff @(posedge clk) begin
      if (!rst_n)    err_q <= 1'b0;
      else if (load) err_q <= src_ill | dst_ill;
   end

   assign cfg_err = err_q;

   AST_ERR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cfg_err == $past(src_ill | dst_ill));                         // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_err));                                           // R8
   AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !load) |=> ($stable(src_addr) && $stable(dst_addr)));      // R8

endmodule

// File: tb/sim_dma_modaddr_gen.sv
`timescale 1ns/1ps
module sim_dma_modaddr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [31:0] ld_src_addr = '0, ld_dst_addr = '0;
   logic [15:0] ld_src_off = '0, ld_dst_off = '0;
   logic [4:0]  ld_src_mod = '0, ld_dst_mod = '0;
   logic [2:0]  ld_src_size = '0, ld_dst_size = '0;
   logic        ld_src_mlo_en = 1'b0, ld_dst_mlo_en = 1'b0;
   logic [19:0] ld_mlo_off = '0;
   logic        src_step = 1'b0, dst_step = 1'b0, minor_done = 1'b0;
   logic [31:0] src_addr, dst_addr;
   logic        cfg_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dma_modaddr_gen u0 (.*);

   function automatic logic [31:0] sx16(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] sx20(input logic [19:0] v);
      return {{12{v[19]}}, v};
   endfunction

   function automatic logic [31:0] model(input logic [31:0] start, input logic [31:0] delta,
                                          input int m);
      logic [31:0] mk;
      mk = (m == 0) ? 32'hFFFF_FFFF : ((32'd1 << m) - 32'd1);
      return (start & ~mk) | ((start + delta) & mk);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_load();
      @(negedge clk); load = 1'b1;
      @(negedge clk); load = 1'b0;
   endtask

   task automatic pulse(input logic s, input logic d, input logic m);
      @(negedge clk); src_step = s; dst_step = d; minor_done = m;
      @(negedge clk); src_step = 1'b0; dst_step = 1'b0; minor_done = 1'b0;
   endtask

   task automatic set_side(input logic [31:0] sa, input logic [15:0] so, input logic [4:0] sm,
                           input logic [31:0] da, input logic [15:0] dof, input logic [4:0] dm);
      ld_src_addr = sa; ld_src_off = so; ld_src_mod = sm;
      ld_dst_addr = da; ld_dst_off = dof; ld_dst_mod = dm;
      ld_src_size = 3'd2; ld_dst_size = 3'd2;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] offs [3];
      logic [31:0] base;
      offs[0] = 16'h0004; offs[1] = 16'hFFF8; offs[2] = 16'h000C;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset src", src_addr, 32'h0);
      chk("R1 reset dst", dst_addr, 32'h0);
      chk("R1 reset err", {31'd0, cfg_err}, 32'h0);

      // R7: sweep every size code on each side
      for (int s = 0; s < 8; s++) begin
         set_side(32'h100, 16'h4, 5'd0, 32'h200, 16'h4, 5'd0);
         ld_src_size = 3'(s);
         do_load();
         chk($sformatf("R7 src size %0d", s), {31'd0, cfg_err},
             {31'd0, (s == 4 || s >= 6)});
      end
      for (int s = 0; s < 8; s++) begin
         set_side(32'h100, 16'h4, 5'd0, 32'h200, 16'h4, 5'd0);
         ld_dst_size = 3'(s);
         do_load();
         chk($sformatf("R7 dst size %0d", s), {31'd0, cfg_err},
             {31'd0, (s == 4 || s >= 6)});
      end

      // R1: load visible
      set_side(32'hDEAD_BEE0, 16'h4, 5'd0, 32'h1357_9BDF, 16'h4, 5'd0);
      do_load();
      chk("R1 load src", src_addr, 32'hDEAD_BEE0);
      chk("R1 load dst", dst_addr, 32'h1357_9BDF);

      // R2/R3/R5: sweep of window size and step, both sides in lock-step
      for (int m = 0; m < 8; m++) begin
         for (int oi = 0; oi < 3; oi++) begin
            set_side(32'hA5A5_5A5C, offs[oi], 5'(m), 32'h3C3C_C3C0, -offs[oi], 5'(m));
            do_load();
            for (int k = 1; k <= 6; k++) begin
               pulse(1'b1, 1'b1, 1'b0);
               chk($sformatf("R2 R5 src m=%0d o=%0d k=%0d", m, oi, k), src_addr,
                   model(32'hA5A5_5A5C, 32'(k) * sx16(offs[oi]), m));
               chk($sformatf("R3 R5 dst m=%0d o=%0d k=%0d", m, oi, k), dst_addr,
                   model(32'h3C3C_C3C0, 32'(k) * sx16(-offs[oi]), m));
            end
         end
      end

      // R5: 16-byte circular queue
      base = 32'h2000_1000;
      set_side(base, 16'h0004, 5'd4, 32'h0, 16'h0, 5'd0);
      do_load();
      for (int k = 1; k <= 4; k++) begin
         pulse(1'b1, 1'b0, 1'b0);
         chk($sformatf("R5 queue step %0d", k), src_addr, base + 32'((4 * k) % 16));
      end
      chk("R5 queue back at base", src_addr, base);

      // R4 / R2: negative step wraps through zero
      set_side(32'h0000_0002, 16'hFFFC, 5'd0, 32'h10, 16'hFFFF, 5'd0);
      do_load();
      pulse(1'b1, 1'b1, 1'b0);
      chk("R4 neg src", src_addr, 32'hFFFF_FFFE);
      chk("R4 neg dst", dst_addr, 32'h0000_000F);

      // R6/R9: step + minor in one cycle under a window; dst enable off
      set_side(32'h4000_00F0, 16'h0010, 5'd8, 32'h0000_1000, 16'h0002, 5'd0);
      ld_mlo_off = 20'h00020; ld_src_mlo_en = 1'b1; ld_dst_mlo_en = 1'b0;
      do_load();
      pulse(1'b1, 1'b0, 1'b1);
      chk("R9 step+minor src window", src_addr, 32'h4000_0020);
      chk("R6 dst enable off unchanged", dst_addr, 32'h0000_1000);

      // R6: negative minor offset on dst only
      set_side(32'h0000_5000, 16'h0004, 5'd0, 32'h0000_1000, 16'h0004, 5'd0);
      ld_mlo_off = 20'hFFFF0; ld_src_mlo_en = 1'b0; ld_dst_mlo_en = 1'b1;
      do_load();
      pulse(1'b0, 1'b0, 1'b1);
      chk("R6 dst minor neg", dst_addr, 32'h0000_1000 + sx20(20'hFFFF0));
      chk("R6 src gated", src_addr, 32'h0000_5000);

      // R9: all three strobes at once, then minor alone
      set_side(32'h0001_0000, 16'h0008, 5'd0, 32'h0002_0000, 16'hFFFE, 5'd0);
      ld_mlo_off = 20'h00100; ld_src_mlo_en = 1'b1; ld_dst_mlo_en = 1'b1;
      do_load();
      pulse(1'b1, 1'b1, 1'b1);
      chk("R9 all src", src_addr, 32'h0001_0108);
      chk("R9 all dst", dst_addr, 32'h0002_00FE);
      pulse(1'b0, 1'b0, 1'b1);
      chk("R9 minor src", src_addr, 32'h0001_0208);
      chk("R9 minor dst", dst_addr, 32'h0002_01FE);
      @(negedge clk);
      chk("R9 idle hold src", src_addr, 32'h0001_0208);

      // R8: reserved code blocks all movement
      set_side(32'h0000_0800, 16'h0004, 5'd0, 32'h0000_0900, 16'h0004, 5'd0);
      ld_dst_size = 3'd6;
      do_load();
      chk("R8 err set", {31'd0, cfg_err}, 32'h1);
      pulse(1'b1, 1'b1, 1'b1);
      chk("R8 src blocked", src_addr, 32'h0000_0800);
      chk("R8 dst blocked", dst_addr, 32'h0000_0900);
      chk("R8 err held", {31'd0, cfg_err}, 32'h1);
      ld_dst_size = 3'd5;
      do_load();
      chk("R8 err cleared", {31'd0, cfg_err}, 32'h0);
      pulse(1'b1, 1'b0, 1'b0);
      chk("R8 src resumes", src_addr, 32'h0000_0804);

      // R10: load coincident with strobes
      set_side(32'h7777_0000, 16'h0040, 5'd0, 32'h8888_0000, 16'h0040, 5'd0);
      @(negedge clk); load = 1'b1; src_step = 1'b1; dst_step = 1'b1; minor_done = 1'b1;
      @(negedge clk); load = 1'b0; src_step = 1'b0; dst_step = 1'b0; minor_done = 1'b0;
      chk("R10 load wins src", src_addr, 32'h7777_0000);
      chk("R10 load wins dst", dst_addr, 32'h8888_0000);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule